// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends bytes out on a single serial line. Software writes a byte into a holding register. At a bit-time boundary, when the shift stage is free, that byte moves into the shift stage. Because of this split, the next byte can be written while the current one is still going out on the line.

Two status flags show progress, at fixed positions of a three-bit status word:

- The empty flag (bit 0) reports whether the holding register can take a new byte.
- The complete flag (bit 2) reports whether the line has finished sending and is idle.

The block has two line formats, selected when a byte is loaded:

- **Clocked mode** sends eight data bits and drives a companion shift clock.
- **Asynchronous mode** wraps each byte in a start bit, an optional parity bit and one or two stop bits.

Bit timing comes from an external one-cycle enable pulse. That pulse must have at least one idle clock cycle between consecutive pulses.

Top module: `sio_tx`

## Requirements
- R1: During and after reset, status[0] (empty) = 1, status[2] (complete) = 1, txd = 1 and sclk = 1.
- R2: A cycle with wr_en = 1 captures wr_data, and status[0] reads 0 from the next cycle on.
- R3: On a bit_tick cycle where the holding register is full and the shifter is idle or its last bit ends, the byte moves into the shifter. From the next cycle status[0] = 1, unless a write arrives in that same cycle.
- R4: The cycle after a load, status[2] = 0 and txd carries the first bit of the new frame.
- R5: On the bit_tick that ends the last bit of a frame with no byte pending, status[2] becomes 1 and txd returns to 1. While nothing is shifting, txd stays 1.
- R6: In clocked mode (mode_uart = 0), the eight data bits go out LSB first, one per bit_tick. sclk is 0 for exactly the clock cycle after each bit is launched and is 1 otherwise. In asynchronous mode sclk stays 1.
- R7: In asynchronous mode (mode_uart = 1), a frame is start bit 0, then eight data bits LSB first, then the parity bit if par_en = 1, then stop bits of 1 (two if two_stop = 1, else one), each lasting one tick interval.
- R8: With par_odd = 0, the parity bit makes the count of ones over data plus parity even. With par_odd = 1, that count is odd.
- R9: A byte waiting when a frame's last bit ends is launched on that same tick, so no idle bit separates the frames and status[2] stays 0.
- R10: A write while status[0] = 0 replaces the waiting byte, and only the last byte written is sent.
- R11: The mode and framing inputs are sampled at load. status[1] always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe into the holding register |
| wr_data | input | DATA_W | Byte to send |
| mode_uart | input | 1 | 1 = asynchronous frame, 0 = clocked |
| bit_tick | input | 1 | One-cycle bit-time enable |
| par_en | input | 1 | Append parity bit (asynchronous mode) |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| two_stop | input | 1 | 1 = two stop bits |
| txd | output | 1 | Serial data line |
| sclk | output | 1 | Shift clock in clocked mode |
| status | output | 3 | {complete, 0, empty} |

## Verification
A behavioural model in the bench holds the pending bits as a queue and is compared with every output on every cycle. The bench covers the following patterns:

- A single byte in clocked mode separates sclk pulse placement and bit order from the asynchronous path.
- Asynchronous bytes with no parity, even parity with two stop bits, and odd parity tell apart the frame length and the parity sense.
- A write issued as soon as empty rises exposes any gap between frames.
- Two writes into a full holding register show whether the older byte is dropped.

// File: rtl/sio_tx_pkg.sv
package sio_tx_pkg;
  typedef enum logic {
    MODE_SYNC = 1'b0,
    MODE_UART = 1'b1
  } line_mode_e;
endpackage

// File: rtl/sio_tx_hold.sv
module sio_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
    end else if (wr_en) begin
      full <= 1'b1;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) data <= wr_data;
  end

  // R2
  write_fills_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> full);
  // R3
  take_empties_chk: assert property (@(posedge clk) disable iff (rst)
    (take && !wr_en) |=> !full);
endmodule

// File: rtl/sio_tx_frame.sv
module sio_tx_frame
  import sio_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data,
  input  line_mode_e         mode,
  input  logic               par_en,
  input  logic               par_odd,
  input  logic               two_stop,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   len
);
  logic par_bit;
  assign par_bit = (^data) ^ par_odd;

  always_comb begin
    frame = '1;
    if (mode == MODE_UART) begin
      frame[0]        = 1'b0;
      frame[DATA_W:1] = data;
      if (par_en) frame[DATA_W+1] = par_bit;
      len = CNT_W'(DATA_W + 2) + CNT_W'(par_en) + CNT_W'(two_stop);
    end else begin
      frame[DATA_W-1:0] = data;
      len = CNT_W'(DATA_W);
    end
  end
endmodule

// File: rtl/sio_tx_shift.sv
module sio_tx_shift
  import sio_tx_pkg::*;
#(
  parameter int FRAME_W = 12,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_tick,
  input  logic               full,
  input  logic [FRAME_W-1:0] frame,
  input  logic [CNT_W-1:0]   len,
  input  line_mode_e         mode,
  output logic               take,
  output logic               txd,
  output logic               sclk,
  output logic               complete
);
  logic               busy;
  logic [FRAME_W-1:0] sreg;
  logic [CNT_W-1:0]   rem;
  line_mode_e         mode_q;

  assign take = bit_tick && full && (!busy || rem == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      sreg     <= '1;
      rem      <= '0;
      txd      <= 1'b1;
      sclk     <= 1'b1;
      complete <= 1'b1;
      mode_q   <= MODE_SYNC;
    end else if (bit_tick) begin
      if (busy && rem != '0) begin
        txd  <= sreg[0];
        sreg <= {1'b1, sreg[FRAME_W-1:1]};
        rem  <= rem - CNT_W'(1);
        sclk <= (mode_q == MODE_UART);
      end else if (full) begin
        txd      <= frame[0];
        sreg     <= {1'b1, frame[FRAME_W-1:1]};
        rem      <= len - CNT_W'(1);
        busy     <= 1'b1;
        complete <= 1'b0;
        mode_q   <= mode;
        sclk     <= (mode == MODE_UART);
      end else begin
        busy     <= 1'b0;
        txd      <= 1'b1;
        complete <= 1'b1;
        sclk     <= 1'b1;
      end
    end else begin
      sclk <= 1'b1;
    end
  end

  // R5
  idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
  // R4
  load_clears_done_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> !complete);
  // R5
  done_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(complete) |-> $past(bit_tick));
  // R6
  sclk_only_sync_chk: assert property (@(posedge clk) disable iff (rst)
    !sclk |-> (busy && mode_q == MODE_SYNC));
endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mode_uart,
  input  logic              bit_tick,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  output logic              txd,
  output logic              sclk,
  output logic [2:0]        status
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic               full, take, complete;
  logic [DATA_W-1:0]  hold_data;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   len;
  line_mode_e         mode;

  assign mode = line_mode_e'(mode_uart);

  sio_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .take(take), .full(full), .data(hold_data)
  );

  sio_tx_frame #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_frame (
    .data(hold_data), .mode(mode), .par_en(par_en), .par_odd(par_odd),
    .two_stop(two_stop), .frame(frame), .len(len)
  );

  sio_tx_shift #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .full(full), .frame(frame),
    .len(len), .mode(mode), .take(take), .txd(txd), .sclk(sclk),
    .complete(complete)
  );

  assign status = {complete, 1'b0, !full};
endmodule

// File: tb/sio_tx_bench.sv
module sio_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       mode_uart = 1'b0;
  logic       bit_tick = 1'b0;
  logic       par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
  logic       txd, sclk;
  logic [2:0] status;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  sio_tx u_sio_tx (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .mode_uart(mode_uart), .bit_tick(bit_tick), .par_en(par_en),
    .par_odd(par_odd), .two_stop(two_stop), .txd(txd), .sclk(sclk),
    .status(status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tick_cnt = 0;
  always @(negedge clk) begin
    tick_cnt = (tick_cnt + 1) % 3;
    bit_tick <= (tick_cnt == 2);
  end

  // reference model
  bit       m_full = 0, m_busy = 0, m_txd = 1, m_sclk = 1, m_cmp = 1, m_uart = 0;
  bit [7:0] m_data = '0;
  bit       q[$];
  int       ones;

  always @(posedge clk) begin
    if (rst) begin
      m_full = 0; m_busy = 0; m_txd = 1; m_sclk = 1; m_cmp = 1;
      q.delete();
    end else begin
      if (bit_tick) begin
        if (m_busy && q.size() > 0) begin
          m_txd  = q.pop_front();
          m_sclk = m_uart;
        end else if (m_full) begin
          m_uart = mode_uart;
          if (m_uart) q.push_back(1'b0);
          ones = 0;
          for (int i = 0; i < 8; i++) begin
            q.push_back(m_data[i]);
            ones += m_data[i];
          end
          if (m_uart) begin
            if (par_en) q.push_back(par_odd ? ((ones % 2) == 0) : ((ones % 2) == 1));
            q.push_back(1'b1);
            if (two_stop) q.push_back(1'b1);
          end
          m_txd  = q.pop_front();
          m_sclk = m_uart;
          m_busy = 1; m_cmp = 0; m_full = 0;
        end else begin
          m_busy = 0; m_txd = 1; m_cmp = 1; m_sclk = 1;
        end
      end else begin
        m_sclk = 1;
      end
      if (wr_en) begin
        m_full = 1;
        m_data = wr_data;
      end
    end
  end

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s) at %0t: actual %b expected %b", req, tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(m_uart ? "R7 txd" : "R6 txd", txd, m_txd);
      check("R6 sclk", sclk, m_sclk);
      check("R2/R3 empty", status[0], !m_full);
      check("R4/R5 complete", status[2], m_cmp);
      check("R11 status1", status[1], 1'b0);
    end
  end

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    wr_en <= 1'b1; wr_data <= b;
    @(negedge clk);
    wr_en <= 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(status[0] && status[2]));
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_loaded();
    do @(negedge clk); while (!status[0]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 txd", txd, 1'b1);
    check("R1 sclk", sclk, 1'b1);
    check("R1 empty", status[0], 1'b1);
    check("R1 complete", status[2], 1'b1);
    rst <= 1'b0;
    repeat (2) @(negedge clk);

    tag = "R6 sync byte";
    put(8'hA5);
    wait_idle();

    tag = "R7 uart 8N1";
    mode_uart <= 1'b1;
    put(8'h3C);
    wait_idle();

    tag = "R8 even parity two stops";
    par_en <= 1'b1; par_odd <= 1'b0; two_stop <= 1'b1;
    put(8'h07);
    wait_idle();

    tag = "R8 odd parity";
    par_odd <= 1'b1; two_stop <= 1'b0;
    put(8'h81);
    wait_idle();

    tag = "R9 back-to-back";
    put(8'h55);
    wait_loaded();
    put(8'hC3);
    wait_loaded();
    put(8'h0F);
    wait_idle();

    tag = "R10 overwrite";
    par_en <= 1'b0;
    put(8'h11);
    wait_loaded();
    put(8'h22);
    put(8'h99);
    wait_idle();

    tag = "R9 sync back-to-back";
    mode_uart <= 1'b0;
    put(8'hF0);
    wait_loaded();
    put(8'h01);
    wait_idle();

    tag = "R11 mode change while pending";
    put(8'h6B);
    mode_uart <= 1'b1;
    wait_idle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule